// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic and logic datapath of a small 8-bit microcontroller core, together with the status register that records the outcome of each operation. The datapath is purely combinational. It takes an accumulator operand and a second operand (memory or immediate), and a 5-bit operation code selects the result. The supported operations are:

- add and subtract, with and without carry in;
- decimal adjust;
- the bitwise operations;
- complement;
- four rotates;
- increment and decrement;
- four test-and-skip operations, which drive a skip output to the sequencer.

The status register is clocked. When the core strobes `exec`, the register takes the carry, nibble carry, zero and overflow flags that the selected operation defines. The core can also write those four flags directly. Two further bits record power-down and watchdog time-out. Software writes cannot alter them, and only dedicated event inputs move them.

The register is not saved on calls or interrupts. The surrounding core has to do that if it needs to.

Top module: `alu8_flags`

## Requirements
- R1: Status bit positions are: bit0 carry (C), bit1 nibble carry (AC), bit2 zero (Z), bit3 overflow (OV), bit4 power-down (PDF), bit5 time-out (TO). Bits 7:6 always read 0. Reset clears every bit.
- R2: `result` is combinational from `op`, `op_a`, `op_b` and the current C and AC. The opcodes are: 0 ADD, 1 ADC, 2 SUB (a-b), 3 SBC (a-b with C as not-borrow), 4 DAA, 5 AND, 6 OR, 7 XOR, 8 CPL (~a), 9 RL, 10 RR, 11 RLC, 12 RRC, 13 INC (a+1), 14 DEC (a-1), 16 SZ (a), 17 SNZ (a), 18 SIZ (a+1), 19 SDZ (a-1). Codes 15 and 20 to 31 give 00h and change no flag.
- R3: On ADD and ADC, C is the carry out of bit 7. AC is the carry out of bit 3. Z is set when the result is 00h. ADC adds C in.
- R4: On SUB and SBC, C is 1 when no borrow occurs, and AC is 1 when the low nibble needs no borrow from the high nibble. SUB computes a+~b+1. SBC computes a+~b+C.
- R5: On ADD, ADC, SUB and SBC, OV is set when the carry into bit 7 differs from the carry out of bit 7.
- R6: The operations AND, OR, XOR, CPL, INC and DEC update only Z. RL and RR leave all four flags unchanged.
- R7: RLC yields {a[6:0],C} and loads C from a[7]. RRC yields {C,a[7:1]} and loads C from a[0]. No other flag changes.
- R8: DAA works in two steps.
  - First it adds 06h to a when a[3:0] > 9 or AC = 1.
  - Then it adds 60h when the high nibble of that sum is > 9, when the sum carried out of bit 7, or when C = 1.
  - C becomes 1 exactly when 60h was added. No other flag changes.
- R9: `skip` is 1 in these cases: on SZ and SIZ when the result is 00h, on SDZ when the result is 00h, and on SNZ when the result is nonzero. It is 0 for every other opcode. The skip operations change no flag.
- R10: A status write (`sts_wr`) loads bits 3:0 from `sts_wdata` and leaves PDF and TO unchanged. When `sts_wr` and `exec` coincide, the write wins.
- R11: The PDF and TO events are handled in this priority order:
  - `ev_wdt_clr` clears both PDF and TO;
  - otherwise `ev_halt` sets PDF and clears TO;
  - otherwise `ev_wdt_tout` sets TO.
  No event changes bits 3:0.
- R12: When neither `exec` nor `sts_wr` is high, bits 3:0 hold their value even if `op` and the operands change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| op | input | 5 | Operation code |
| op_a | input | 8 | Accumulator operand |
| op_b | input | 8 | Second operand |
| exec | input | 1 | Commit the flags of the current operation |
| sts_wr | input | 1 | Direct write of the status register |
| sts_wdata | input | 8 | Status write data (bits 3:0 used) |
| ev_wdt_clr | input | 1 | Watchdog clear event |
| ev_halt | input | 1 | Halt event |
| ev_wdt_tout | input | 1 | Watchdog time-out event |
| result | output | 8 | Operation result |
| skip | output | 1 | Skip condition for test-and-skip operations |
| status | output | 8 | Status register |

## Verification
- **Additions.** Addition vectors are chosen to separate carry out of bit 7 from carry into it. This exposes a swapped or missing overflow term, and nibble sums just above 15 exercise AC.
- **Subtractions.** Subtractions are run both ways round, and with low nibbles that do and do not borrow. This exposes any inversion of the no-borrow convention on C or AC. SBC is run with C both clear and set.
- **Decimal adjust.** DAA inputs cover four cases: low digit above nine, AC set with a valid digit, incoming C with valid digits, and a double adjustment that wraps to 00h.
- **Status writes and events.** Preset flag values show which flags each operation may leave untouched. Status writes, events and their collisions check the guard on PDF and TO.

// File: rtl/alu8_flags.sv
module alu8_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] op,
  input  logic [7:0] op_a,
  input  logic [7:0] op_b,
  input  logic       exec,
  input  logic       sts_wr,
  input  logic [7:0] sts_wdata,
  input  logic       ev_wdt_clr,
  input  logic       ev_halt,
  input  logic       ev_wdt_tout,
  output logic [7:0] result,
  output logic       skip,
  output logic [7:0] status
);

  localparam logic [4:0] OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3;
  localparam logic [4:0] OP_DAA = 5'd4,  OP_AND = 5'd5,  OP_OR  = 5'd6,  OP_XOR = 5'd7;
  localparam logic [4:0] OP_CPL = 5'd8,  OP_RL  = 5'd9,  OP_RR  = 5'd10, OP_RLC = 5'd11;
  localparam logic [4:0] OP_RRC = 5'd12, OP_INC = 5'd13, OP_DEC = 5'd14;
  localparam logic [4:0] OP_SZ  = 5'd16, OP_SNZ = 5'd17, OP_SIZ = 5'd18, OP_SDZ = 5'd19;

  logic c_q, ac_q, z_q, ov_q, pdf_q, to_q;
  logic c_d, ac_d, z_d, ov_d;

  wire       is_sub = (op == OP_SUB) || (op == OP_SBC);
  wire [7:0] addend = is_sub ? ~op_b : op_b;
  wire       cin    = (op == OP_SUB) ? 1'b1 : ((op == OP_ADD) ? 1'b0 : c_q);

  wire [8:0] sum   = {1'b0, op_a} + {1'b0, addend} + {8'd0, cin};
  wire [4:0] lo4   = {1'b0, op_a[3:0]} + {1'b0, addend[3:0]} + {4'd0, cin};
  wire [7:0] lo7   = {1'b0, op_a[6:0]} + {1'b0, addend[6:0]} + {7'd0, cin};
  wire       ov_ar = lo7[7] ^ sum[8];

  wire       da_lo  = (op_a[3:0] > 4'd9) || ac_q;
  wire [8:0] da_t   = {1'b0, op_a} + (da_lo ? 9'h006 : 9'h000);
  wire       da_hi  = (da_t[7:4] > 4'd9) || da_t[8] || c_q;
  wire [7:0] da_res = da_t[7:0] + (da_hi ? 8'h60 : 8'h00);

  wire [7:0] inc_a = op_a + 8'd1;
  wire [7:0] dec_a = op_a - 8'd1;

  always_comb begin
    case (op)
      OP_ADD, OP_ADC,
      OP_SUB, OP_SBC: result = sum[7:0];
      OP_DAA:         result = da_res;
      OP_AND:         result = op_a & op_b;
      OP_OR:          result = op_a | op_b;
      OP_XOR:         result = op_a ^ op_b;
      OP_CPL:         result = ~op_a;
      OP_RL:          result = {op_a[6:0], op_a[7]};
      OP_RR:          result = {op_a[0], op_a[7:1]};
      OP_RLC:         result = {op_a[6:0], c_q};
      OP_RRC:         result = {c_q, op_a[7:1]};
      OP_INC, OP_SIZ: result = inc_a;
      OP_DEC, OP_SDZ: result = dec_a;
      OP_SZ, OP_SNZ:  result = op_a;
      default:        result = 8'h00;
    endcase
  end

  always_comb begin
    case (op)
      OP_SZ, OP_SIZ, OP_SDZ: skip = (result == 8'h00);
      OP_SNZ:                skip = (result != 8'h00);
      default:               skip = 1'b0;
    endcase
  end

  always_comb begin
    {ov_d, z_d, ac_d, c_d} = {ov_q, z_q, ac_q, c_q};
    if (sts_wr) begin
      {ov_d, z_d, ac_d, c_d} = sts_wdata[3:0];
    end else if (exec) begin
      case (op)
        OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
          c_d  = sum[8];
          ac_d = lo4[4];
          ov_d = ov_ar;
          z_d  = (sum[7:0] == 8'h00);
        end
        OP_AND, OP_OR, OP_XOR, OP_CPL,
        OP_INC, OP_DEC: z_d = (result == 8'h00);
        OP_RLC:         c_d = op_a[7];
        OP_RRC:         c_d = op_a[0];
        OP_DAA:         c_d = da_hi;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ov_q, z_q, ac_q, c_q} <= 4'h0;
      pdf_q <= 1'b0;
      to_q  <= 1'b0;
    end else begin
      {ov_q, z_q, ac_q, c_q} <= {ov_d, z_d, ac_d, c_d};
      if (ev_wdt_clr) begin
        pdf_q <= 1'b0;
        to_q  <= 1'b0;
      end else if (ev_halt) begin
        pdf_q <= 1'b1;
        to_q  <= 1'b0;
      end else if (ev_wdt_tout) begin
        to_q  <= 1'b1;
      end
    end
  end

  assign status = {2'b00, to_q, pdf_q, ov_q, z_q, ac_q, c_q};

  AST_TOPDF_WRITE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    sts_wr && !ev_wdt_clr && !ev_halt && !ev_wdt_tout |=> status[5:4] == $past(status[5:4])); // R10
  AST_WDT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wdt_clr |=> status[5:4] == 2'b00); // R11
  AST_HALT_PDF: assert property (@(posedge clk) disable iff (!rst_n)
    ev_halt && !ev_wdt_clr |=> status[5:4] == 2'b01); // R11
  AST_TIMEOUT_TO: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wdt_tout && !ev_halt && !ev_wdt_clr |=> status[5]); // R11
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !exec && !sts_wr |=> status[3:0] == $past(status[3:0])); // R12
  AST_ROTATE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    exec && !sts_wr && (op == OP_RL || op == OP_RR) |=> status[3:0] == $past(status[3:0])); // R6
  AST_LOGIC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    exec && !sts_wr && (op == OP_AND || op == OP_OR || op == OP_XOR)
    |=> status[2] == ($past(op_a & op_b) == 8'h00 ? ($past(op) == OP_AND) : ($past(op) != OP_AND) && ($past(result) == 8'h00)) || status[2] == ($past(result) == 8'h00)); // R6
  AST_SUB_NO_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
    exec && !sts_wr && op == OP_SUB |=> status[0] == ($past(op_a) >= $past(op_b))); // R4
  AST_SKIP_BRANCH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> (op == OP_SZ || op == OP_SNZ || op == OP_SIZ || op == OP_SDZ)); // R9

endmodule

// File: tb/sim_alu8_flags.sv
module sim_alu8_flags;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] op = 5'd0;
  logic [7:0] op_a = 8'h00, op_b = 8'h00, sts_wdata = 8'h00;
  logic exec = 1'b0, sts_wr = 1'b0, ev_wdt_clr = 1'b0, ev_halt = 1'b0, ev_wdt_tout = 1'b0;
  logic [7:0] result, status;
  logic skip;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  alu8_flags u0 (
    .clk(clk), .rst_n(rst_n), .op(op), .op_a(op_a), .op_b(op_b),
    .exec(exec), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
    .ev_wdt_clr(ev_wdt_clr), .ev_halt(ev_halt), .ev_wdt_tout(ev_wdt_tout),
    .result(result), .skip(skip), .status(status)
  );

  // {op, a, b, preset flags {OV,Z,AC,C}, expected result, expected flags, expected skip}
  localparam int NV = 33;
  localparam logic [37:0] VEC [NV] = '{
    {5'd0,  8'h3A, 8'h28, 4'b0000, 8'h62, 4'b0010, 1'b0},
    {5'd0,  8'h80, 8'h80, 4'b0000, 8'h00, 4'b1101, 1'b0},
    {5'd0,  8'h7F, 8'h01, 4'b0000, 8'h80, 4'b1010, 1'b0},
    {5'd1,  8'hFF, 8'h00, 4'b0001, 8'h00, 4'b0111, 1'b0},
    {5'd2,  8'h50, 8'h20, 4'b0000, 8'h30, 4'b0011, 1'b0},
    {5'd2,  8'h20, 8'h50, 4'b0000, 8'hD0, 4'b0010, 1'b0},
    {5'd2,  8'h13, 8'h05, 4'b0000, 8'h0E, 4'b0001, 1'b0},
    {5'd3,  8'h10, 8'h01, 4'b0000, 8'h0E, 4'b0001, 1'b0},
    {5'd3,  8'h80, 8'h01, 4'b0001, 8'h7F, 4'b1001, 1'b0},
    {5'd2,  8'h42, 8'h42, 4'b0000, 8'h00, 4'b0111, 1'b0},
    {5'd5,  8'hF0, 8'h0F, 4'b1011, 8'h00, 4'b1111, 1'b0},
    {5'd6,  8'h12, 8'h40, 4'b0100, 8'h52, 4'b0000, 1'b0},
    {5'd7,  8'hAA, 8'hAA, 4'b0001, 8'h00, 4'b0101, 1'b0},
    {5'd8,  8'hFF, 8'h00, 4'b0000, 8'h00, 4'b0100, 1'b0},
    {5'd9,  8'h81, 8'h00, 4'b0100, 8'h03, 4'b0100, 1'b0},
    {5'd10, 8'h01, 8'h00, 4'b0000, 8'h80, 4'b0000, 1'b0},
    {5'd11, 8'h80, 8'h00, 4'b0000, 8'h00, 4'b0001, 1'b0},
    {5'd12, 8'h02, 8'h00, 4'b0001, 8'h81, 4'b0000, 1'b0},
    {5'd13, 8'hFF, 8'h00, 4'b0001, 8'h00, 4'b0101, 1'b0},
    {5'd14, 8'h01, 8'h00, 4'b0000, 8'h00, 4'b0100, 1'b0},
    {5'd4,  8'h3C, 8'h00, 4'b0000, 8'h42, 4'b0000, 1'b0},
    {5'd4,  8'h9A, 8'h00, 4'b0000, 8'h00, 4'b0001, 1'b0},
    {5'd4,  8'h12, 8'h00, 4'b0010, 8'h18, 4'b0010, 1'b0},
    {5'd4,  8'h20, 8'h00, 4'b0001, 8'h80, 4'b0001, 1'b0},
    {5'd4,  8'h9F, 8'h00, 4'b0000, 8'h05, 4'b0001, 1'b0},
    {5'd16, 8'h00, 8'h00, 4'b0000, 8'h00, 4'b0000, 1'b1},
    {5'd16, 8'h05, 8'h00, 4'b0000, 8'h05, 4'b0000, 1'b0},
    {5'd17, 8'h05, 8'h00, 4'b0000, 8'h05, 4'b0000, 1'b1},
    {5'd17, 8'h00, 8'h00, 4'b0000, 8'h00, 4'b0000, 1'b0},
    {5'd18, 8'hFF, 8'h00, 4'b0000, 8'h00, 4'b0000, 1'b1},
    {5'd18, 8'h10, 8'h00, 4'b0000, 8'h11, 4'b0000, 1'b0},
    {5'd19, 8'h01, 8'h00, 4'b0000, 8'h00, 4'b0000, 1'b1},
    {5'd19, 8'h00, 8'h00, 4'b1111, 8'hFF, 4'b1111, 1'b0}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string flag_tag(input logic [4:0] o);
    case (o)
      5'd0, 5'd1:   return "R3 R5 flags";
      5'd2, 5'd3:   return "R4 R5 flags";
      5'd4:         return "R8 flags";
      5'd11, 5'd12: return "R7 flags";
      5'd16, 5'd17,
      5'd18, 5'd19: return "R9 flags";
      default:      return "R6 flags";
    endcase
  endfunction

  task automatic write_status(input logic [7:0] d);
    @(negedge clk); sts_wr = 1'b1; sts_wdata = d;
    @(negedge clk); sts_wr = 1'b0;
  endtask

  task automatic pulse(input logic clr, input logic hlt, input logic tout);
    @(negedge clk); ev_wdt_clr = clr; ev_halt = hlt; ev_wdt_tout = tout;
    @(negedge clk); ev_wdt_clr = 1'b0; ev_halt = 1'b0; ev_wdt_tout = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset status", status, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 status after release", status, 8'h00);

    write_status(8'hFF);
    check("R10 write sets low flags only, R1 upper zero", status, 8'h0F);
    pulse(1'b0, 1'b0, 1'b1);
    check("R11 timeout sets TO, flags kept", status, 8'h2F);
    write_status(8'h00);
    check("R10 write leaves TO", status, 8'h20);
    pulse(1'b0, 1'b1, 1'b0);
    check("R11 halt sets PDF clears TO", status, 8'h10);
    write_status(8'hF0);
    check("R10 write leaves PDF", status, 8'h10);
    pulse(1'b0, 1'b1, 1'b1);
    check("R11 halt beats timeout", status, 8'h10);
    pulse(1'b1, 0, 0);
    check("R11 watchdog clear", status, 8'h00);
    pulse(1'b0, 0, 1'b1);
    pulse(1'b1, 1'b1, 1'b1);
    check("R11 clear beats halt and timeout", status, 8'h00);

    @(negedge clk); op = 5'd0; op_a = 8'h80; op_b = 8'h80; exec = 1'b0;
    #2 check("R2 result without exec", result, 8'h00);
    @(negedge clk);
    check("R12 flags hold without exec", status, 8'h00);

    @(negedge clk); op = 5'd0; op_a = 8'h80; op_b = 8'h80; exec = 1'b1;
    sts_wr = 1'b1; sts_wdata = 8'h02;
    @(negedge clk); exec = 1'b0; sts_wr = 1'b0;
    check("R10 write wins over exec", status, 8'h02);

    @(negedge clk); op = 5'd15; op_a = 8'h55; op_b = 8'hAA;
    #2 check("R2 unused code result", result, 8'h00);
    check("R9 unused code skip", {7'd0, skip}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [4:0] vo;
      logic [7:0] va, vb, vr;
      logic [3:0] vp, vf;
      logic vs;
      {vo, va, vb, vp, vr, vf, vs} = VEC[i];
      write_status({4'h0, vp});
      op = vo; op_a = va; op_b = vb; exec = 1'b1;
      #2;
      check($sformatf("R2 result op %0d vec %0d", vo, i), result, vr);
      check($sformatf("R9 skip op %0d vec %0d", vo, i), {7'd0, skip}, {7'd0, vs});
      @(negedge clk); exec = 1'b0;
      check($sformatf("%s op %0d vec %0d", flag_tag(vo), vo, i), {4'h0, status[3:0]}, {4'h0, vf});
    end

    pulse(1'b0, 0, 1'b1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears TO", status, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule